// File: doc/BRIEF.md
# Per-Thread Duty-Cycle Participation Control

This block decides, for every logical thread of a multi-thread package, whether that thread may be placed into the hardware duty-cycled forced-idle state. Each thread owns a one-bit participation register that software reaches through a shared request port addressed by thread number. Every request completes one cycle after acceptance and is marked by a done pulse. A capability strap makes the participation bits writable. Writes that set any reserved bit are rejected.

The package-wide enable reaches the threads through a configurable delay line. This delay is longer than the time a register write takes to complete. When the delayed enable rises, each thread's participation output is loaded from its register. The outputs then hold until the delayed enable falls, and the fall clears them at once. A mode input selects one of two policies. In the first, each thread is gated separately. In the second, a single excluded thread withdraws duty cycling from the whole package. A package permit output is high while any thread participates.

Top module: `dcpc_top`

## Requirements
- R1: Bit 0 of a thread's register is its allow bit (1 = participate, 0 = excluded). On a rise of the delayed enable, each thread's participation output takes the value of its allow bit.
- R2: After reset every allow bit is 1, every participation output is 0, the permit is 0 and no done pulse is present.
- R3: While the capability strap is 0, a write pulses done with no error and leaves the allow bit unchanged.
- R4: A write with any of bits DATA_W-1:1 set pulses done with the error flag and leaves the allow bit unchanged. Reads return 0 in bits DATA_W-1:1.
- R5: A request sampled at clock edge k completes at edge k+1, and done is high for the one cycle after edge k+1. A read returns the thread's allow bit in bit 0 of the read data during that cycle. Write completions return all-zero read data.
- R6: While the delayed enable stays high and the mode is unchanged, the participation outputs do not change, even when allow bits are rewritten.
- R7: The package enable sampled at edge k takes effect at the outputs at edge k+EN_DELAY-1. With the default of 4, outputs change 4 edges after the input is driven between edges.
- R8: When the delayed enable is 0, every participation output is 0, whatever the allow bits hold.
- R9: With mode 0, each thread is gated by its own latched bit. With mode 1, all outputs are 1 only if every latched bit is 1, and otherwise all are 0. The mode acts without a clock delay.
- R10: The permit output is 1 exactly when at least one participation output is 1.
- R11: A write that completes on the same edge where the delayed enable rises is not honored by that rise. The previous allow value is latched instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_strap | input | 1 | Duty-cycling capability; 1 makes allow bits writable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_thread | input | TID_W | Target thread number |
| req_wdata | input | DATA_W | Write data; bit 0 is the allow bit |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Write rejected for nonzero reserved bits |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| pkg_en | input | 1 | Package duty-cycle enable, before the delay line |
| mode_pkg | input | 1 | 0 = per-thread gating, 1 = package-wide withdrawal |
| thread_part | output | N_THREADS | Per-thread participation |
| dc_permit | output | 1 | Package duty-cycle permit |

## Verification
The bench writes an allow bit so that the write completes on exactly the edge where the delayed enable rises. A design that honored that write would latch the new value instead of the old one. It rewrites allow bits while the enable is high; a design that follows the registers live would change its outputs before the next rise. It checks the outputs one cycle before and at the expected delay, which catches a delay line that is one stage off. It also drives rejected and read-only writes, and a design that changed state on either would read back the wrong bit. Package-withdrawal mode is exercised with a single blocked thread, which a per-thread-only design would leave partly enabled.

// File: rtl/dcpc_pkg.sv
package dcpc_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_REJECT = 3'd3,
        OP_IGNORE = 3'd4
    } req_op_e;

    typedef enum logic {
        GATE_THREAD  = 1'b0,
        GATE_PACKAGE = 1'b1
    } gate_mode_e;

endpackage

// File: rtl/dcpc_req_port.sv
module dcpc_req_port
    import dcpc_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int DATA_W    = 64,
    parameter int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_strap,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TID_W-1:0]     req_thread,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [N_THREADS-1:0] allow_o,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata
);

    typedef struct packed {
        req_op_e                op;
        logic [TID_W-1:0]       tid;
        logic                   wbit;
        logic [N_THREADS-1:0]   allow;
        logic                   done;
        logic                   err;
        logic                   rbit;
    } port_state_t;

    port_state_t s_d, s_q;
    logic        tid_ok;
    logic        rsv_set;

    assign tid_ok  = (int'(s_q.tid) < N_THREADS);
    assign rsv_set = |req_wdata[DATA_W-1:1];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        s_d.rbit = 1'b0;

        // complete the request accepted on the previous edge
        case (s_q.op)
            OP_WRITE: begin
                s_d.done = 1'b1;
                if (tid_ok) s_d.allow[s_q.tid] = s_q.wbit;
            end
            OP_READ: begin
                s_d.done = 1'b1;
                if (tid_ok) s_d.rbit = s_q.allow[s_q.tid];
            end
            OP_REJECT: begin
                s_d.done = 1'b1;
                s_d.err  = 1'b1;
            end
            OP_IGNORE: begin
                s_d.done = 1'b1;
            end
            default: ;
        endcase

        // accept a new request
        s_d.op   = OP_NONE;
        s_d.tid  = req_thread;
        s_d.wbit = req_wdata[0];
        if (req_valid) begin
            if (!req_write)      s_d.op = OP_READ;
            else if (rsv_set)    s_d.op = OP_REJECT;
            else if (!cap_strap) s_d.op = OP_IGNORE;
            else                 s_d.op = OP_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.op    <= OP_NONE;
            s_q.tid   <= '0;
            s_q.wbit  <= 1'b0;
            s_q.allow <= '1;
            s_q.done  <= 1'b0;
            s_q.err   <= 1'b0;
            s_q.rbit  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign allow_o   = s_q.allow;
    assign rsp_done  = s_q.done;
    assign rsp_err   = s_q.err;
    assign rsp_rdata = {{(DATA_W-1){1'b0}}, s_q.rbit};

endmodule

// File: rtl/dcpc_en_delay.sv
module dcpc_en_delay #(
    parameter int EN_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkg_en,
    output logic active_o,
    output logic next_active_o,
    output logic rise_o
);

    typedef struct packed {
        logic [EN_DELAY-1:0] sh;
    } dly_state_t;

    dly_state_t s_d, s_q;

    generate
        if (EN_DELAY == 1) begin : g_single
            always_comb begin
                s_d.sh = pkg_en;
            end
            assign next_active_o = pkg_en;
        end else begin : g_chain
            always_comb begin
                s_d.sh = {s_q.sh[EN_DELAY-2:0], pkg_en};
            end
            assign next_active_o = s_q.sh[EN_DELAY-2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.sh[EN_DELAY-1];
    assign rise_o   = next_active_o & ~s_q.sh[EN_DELAY-1];

endmodule

// File: rtl/dcpc_part_gate.sv
module dcpc_part_gate
    import dcpc_pkg::*;
#(
    parameter int N_THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] allow_i,
    input  logic                 next_active_i,
    input  logic                 rise_i,
    input  logic                 mode_pkg,
    output logic [N_THREADS-1:0] part_o,
    output logic                 permit_o
);

    typedef struct packed {
        logic [N_THREADS-1:0] lat;
    } gate_state_t;

    gate_state_t s_d, s_q;
    gate_mode_e  mode;
    logic        all_in;

    assign mode   = gate_mode_e'(mode_pkg);
    assign all_in = &s_q.lat;

    always_comb begin
        s_d = s_q;
        if (!next_active_i) s_d.lat = '0;
        else if (rise_i)    s_d.lat = allow_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
            assign part_o[g] = (mode == GATE_PACKAGE) ? all_in : s_q.lat[g];
        end
    endgenerate

    assign permit_o = |part_o;

endmodule

// File: rtl/dcpc_top.sv
module dcpc_top #(
    parameter int N_THREADS = 4,
    parameter int DATA_W    = 64,
    parameter int EN_DELAY  = 4,
    parameter int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_strap,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TID_W-1:0]     req_thread,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 pkg_en,
    input  logic                 mode_pkg,
    output logic [N_THREADS-1:0] thread_part,
    output logic                 dc_permit
);

    logic [N_THREADS-1:0] allow;
    logic                 en_active;
    logic                 en_next;
    logic                 en_rise;

    dcpc_req_port #(
        .N_THREADS (N_THREADS),
        .DATA_W    (DATA_W),
        .TID_W     (TID_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_strap  (cap_strap),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_thread (req_thread),
        .req_wdata  (req_wdata),
        .allow_o    (allow),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    dcpc_en_delay #(
        .EN_DELAY (EN_DELAY)
    ) u_dly (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkg_en        (pkg_en),
        .active_o      (en_active),
        .next_active_o (en_next),
        .rise_o        (en_rise)
    );

    dcpc_part_gate #(
        .N_THREADS (N_THREADS)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .allow_i       (allow),
        .next_active_i (en_next),
        .rise_i        (en_rise),
        .mode_pkg      (mode_pkg),
        .part_o        (thread_part),
        .permit_o      (dc_permit)
    );

endmodule

// File: rtl/dcpc_checker.sv
module dcpc_checker #(
    parameter int N_THREADS = 4,
    parameter int DATA_W    = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_done,
    input logic                 rsp_err,
    input logic [DATA_W-1:0]    rsp_rdata,
    input logic                 mode_pkg,
    input logic [N_THREADS-1:0] thread_part,
    input logic                 dc_permit,
    input logic                 en_active
);

    p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_done);

    p_err_has_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    p_rsv_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_rdata[DATA_W-1:1] == '0));

    p_inactive_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_active |-> (thread_part == '0));

    p_all_or_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pkg |-> ((thread_part == '0) || (&thread_part)));

    p_hold_while_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_active && $past(en_active) && $stable(mode_pkg)) |-> $stable(thread_part));

    p_permit_needs_part_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dc_permit |-> (thread_part != '0));

endmodule

bind dcpc_top dcpc_checker #(
    .N_THREADS (N_THREADS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .mode_pkg    (mode_pkg),
    .thread_part (thread_part),
    .dc_permit   (dc_permit),
    .en_active   (en_active)
);

// File: tb/tb_dcpc_top.sv
module tb_dcpc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 4;
    localparam int DW         = 64;
    localparam int DLY        = 4;
    localparam int TW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_strap = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [TW-1:0] req_thread = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          pkg_en = 1'b0;
    logic          mode_pkg = 1'b0;
    logic [NT-1:0] thread_part;
    logic          dc_permit;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic          err;
        logic [DW-1:0] rdata;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcpc_top #(.N_THREADS(NT), .DATA_W(DW), .EN_DELAY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .cap_strap(cap_strap),
        .req_valid(req_valid), .req_write(req_write), .req_thread(req_thread),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .pkg_en(pkg_en), .mode_pkg(mode_pkg),
        .thread_part(thread_part), .dc_permit(dc_permit)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(int tid, logic [DW-1:0] data, logic exp_err, string tag);
        exp_t e;
        e.err = exp_err; e.rdata = '0; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = 1'b1;
        req_thread = TW'(tid); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic do_read(int tid, logic bitv, string tag);
        exp_t e;
        e.err = 1'b0; e.rdata = {{(DW-1){1'b0}}, bitv}; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = 1'b0; req_thread = TW'(tid);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " err"}, 64'(rsp_err), 64'(e.err));
                chk({e.tag, " rdata"}, rsp_rdata, e.rdata);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R2 reset state
        chk("R2 parts after reset", 64'(thread_part), 64'h0);
        chk("R2 permit after reset", 64'(dc_permit), 64'h0);
        chk("R2 no done after reset", 64'(rsp_done), 64'h0);
        for (int t = 0; t < NT; t++) do_read(t, 1'b1, "R2 reset allow read");

        // R7 latency and R1 first rise
        pkg_en = 1'b1;
        tick(DLY - 1);
        chk("R7 not yet active", 64'(thread_part), 64'h0);
        tick(1);
        chk("R1 all participate", 64'(thread_part), 64'hF);
        chk("R10 permit on", 64'(dc_permit), 64'h1);

        // R6 rewrite while high has no effect
        do_write(1, 64'h0, 1'b0, "R6 write t1");
        tick(2);
        chk("R6 parts held", 64'(thread_part), 64'hF);

        // R8 fall clears, after the delay
        pkg_en = 1'b0;
        tick(DLY - 1);
        chk("R7 fall not yet seen", 64'(thread_part), 64'hF);
        tick(1);
        chk("R8 parts cleared", 64'(thread_part), 64'h0);
        chk("R10 permit off", 64'(dc_permit), 64'h0);

        // R1 new rise latches the written value
        pkg_en = 1'b1;
        tick(DLY);
        chk("R1 thread1 blocked", 64'(thread_part), 64'hD);

        // R9 package withdrawal
        mode_pkg = 1'b1;
        tick(1);
        chk("R9 package mode withdraws", 64'(thread_part), 64'h0);
        chk("R9 permit withdrawn", 64'(dc_permit), 64'h0);
        mode_pkg = 1'b0;
        tick(1);
        chk("R9 per-thread mode back", 64'(thread_part), 64'hD);

        // R4 reserved bits rejected
        do_write(2, 64'h21, 1'b1, "R4 reserved write");
        do_read(2, 1'b1, "R4 value kept");
        do_write(3, 64'h8000_0000_0000_0000, 1'b1, "R4 top reserved bit");
        do_read(3, 1'b1, "R4 t3 kept");

        // R3 strap low makes writes ineffective
        cap_strap = 1'b0;
        do_write(0, 64'h0, 1'b0, "R3 write with strap low");
        cap_strap = 1'b1;
        do_read(0, 1'b1, "R3 t0 unchanged");
        tick(2);
        chk("R6 parts after port traffic", 64'(thread_part), 64'hD);

        // R11 write completing on the rise edge is not honored
        pkg_en = 1'b0;
        tick(DLY + 1);
        pkg_en = 1'b1;
        tick(DLY - 2);
        do_write(3, 64'h0, 1'b0, "R11 write t3");
        tick(1);
        chk("R11 old t3 value latched", 64'(thread_part), 64'hD);
        do_read(3, 1'b0, "R11 t3 now zero");

        // R6/R1 next rise picks the completed write
        pkg_en = 1'b0;
        tick(DLY + 1);
        pkg_en = 1'b1;
        tick(DLY);
        chk("R1 t3 now blocked", 64'(thread_part), 64'h5);

        // R10 all blocked gives no permit
        for (int t = 0; t < NT; t++) do_write(t, 64'h0, 1'b0, "R10 block all");
        pkg_en = 1'b0;
        tick(DLY + 1);
        pkg_en = 1'b1;
        tick(DLY);
        chk("R10 no thread", 64'(thread_part), 64'h0);
        chk("R10 permit low", 64'(dc_permit), 64'h0);

        tick(4);
        chk("R5 all responses seen", 64'(exp_q.size()), 64'h0);
        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule